// File: doc/BRIEF.md
# Addressed serial bus slave endpoint

This block is the slave end of a two-wire synchronous serial bus built from a controller-driven clock and one shared, pulled-low data line. It runs on a fast local clock and oversamples the bus clock and data. From that it assembles 12-bit frames. Each frame has a start bit, a type bit (low for control, high for data), a turnaround bit, eight data bits sent LSB first, and a second turnaround bit. Control frames are decoded into addressing and transfer commands. Data frames are then either taken in from the controller or answered by driving the data line.

The slave carries a 6-bit address fixed by a parameter. A select command with a matching address makes it the active slave. It then answers the next data-input frame with a fixed, nonzero information byte. Transfer commands set the direction, byte or byte-pair size, and single or repeated mode, and pass a 4-bit command nibble to the attached logic. The attached logic sees a receive strobe with a byte, a transmit request strobe that asks for the next byte, and a reset pulse.

Top module: `sbus_slave`

## Requirements
- R1: After reset, the data-line enable, the data-line output and all strobes are low, and the slave is unselected.
- R2: A frame starts only on a bus-clock rising edge that samples the data line high. Low samples outside a frame, including a whole null frame of twelve lows, are skipped, and the next high start bit begins a frame.
- R3: A control byte with bit 7 = 0, bit 6 = 1 and bits 5..0 equal to the parameter address selects the slave. The next data-input frame (type bit high) is answered with the information byte. After that the slave waits for a control byte only.
- R4: A select with bit 6 = 1 and a different nonzero address, or with address 0 (deselect), leaves the slave unselected. An unselected slave ignores data frames and never drives the line.
- R5: A control byte with bits 7 and 6 both 0 and address 0 or the own address pulses `dev_reset` for one clock and deselects the slave. The same command with another address has no effect.
- R6: While the slave is selected, a control byte with bit 7 = 1 presents bits 3..0 on `cmd_nibble` with a one-clock `cmd_strobe`. Bit 6 = 1 means read, bit 5 = 1 means byte pair, and bit 4 = 1 means repeated. An unselected slave ignores such a byte.
- R7: In a write state, each data frame gives one `rx_strobe` with the eight data bits. The first data bit is `rx_byte[0]`.
- R8: In a read state, the slave drives the line exactly during the eight data-bit periods of a data frame, sending `tx_byte` LSB first. It releases the line at the end of the last data bit and never drives during the start, type or turnaround bits.
- R9: In single mode, the slave returns to control-only waiting after one transfer. In repeated mode, it keeps transferring until the next control byte. `tx_req` pulses on entry to a read state and after each read transfer that leaves it in a read state.
- R10: A byte-pair transfer takes two consecutive data frames, low byte first. A single byte-pair command ends after the second frame.
- R11: A control byte is accepted in every waiting state, including partway through a repeated transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_clk | input | 1 | Bus clock from the controller |
| bus_dat_in | input | 1 | Data line as seen at the pin |
| bus_dat_out | output | 1 | Value driven onto the data line |
| bus_dat_oe | output | 1 | Data-line drive enable |
| rx_strobe | output | 1 | One-clock pulse: a byte was received |
| rx_byte | output | 8 | Last received byte |
| tx_req | output | 1 | One-clock pulse: present the next transmit byte |
| tx_byte | input | 8 | Byte to transmit in the next data-input frame |
| cmd_nibble | output | 4 | Low nibble of the last accepted transfer command |
| cmd_strobe | output | 1 | One-clock pulse: a transfer command was accepted |
| dev_reset | output | 1 | One-clock reset pulse to the attached device |

## Verification
Bus inputs pass through two synchronising stages, so the drive enable and the transmitted bit change three local clocks after the bus-clock falling edge that triggers them. The strobes and `rx_byte` change three local clocks after the rising edge of the final turnaround bit. The bench holds each bus-clock phase for eight local clocks and samples the data line and drive enable one phase after each change, just before the next rising edge. It counts strobes on the falling local clock edge and compares those counts six clocks after the final falling edge of a frame. By then every result of that frame has settled.

// File: rtl/sbus_slave.sv
module sbus_slave #(
  parameter logic [5:0] DEV_ID    = 6'h15,
  parameter logic [7:0] INFO_BYTE = 8'h3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_clk,
  input  logic       bus_dat_in,
  output logic       bus_dat_out,
  output logic       bus_dat_oe,
  output logic       rx_strobe,
  output logic [7:0] rx_byte,
  output logic       tx_req,
  input  logic [7:0] tx_byte,
  output logic [3:0] cmd_nibble,
  output logic       cmd_strobe,
  output logic       dev_reset
);
  localparam logic [3:0] LAST_BIT = 4'd11;
  localparam logic [3:0] D0_BIT   = 4'd3;
  localparam logic [3:0] D7_BIT   = 4'd10;

  typedef enum logic [2:0] {W_CTL, W_RXB, W_RXW, W_TXB, W_TXW} wait_e;

  logic [2:0] ck_s;
  logic [1:0] dt_s;
  logic [3:0] cnt_q;
  logic       ctl_q, sel_q, multi_q, hi_q, info_q;
  logic [7:0] sh_q, txsh_q;
  wait_e      st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_s <= '0;
      dt_s <= '0;
    end else begin
      ck_s <= {ck_s[1:0], bus_clk};
      dt_s <= {dt_s[0], bus_dat_in};
    end
  end

  wire rise_w  = ck_s[1] & ~ck_s[2];
  wire fall_w  = ~ck_s[1] & ck_s[2];
  wire bit_w   = dt_s[1];
  wire is_tx   = (st_q == W_TXB) || (st_q == W_TXW);
  wire is_word = (st_q == W_RXW) || (st_q == W_TXW);
  wire id_zero = (sh_q[5:0] == 6'd0);
  wire id_hit  = (sh_q[5:0] == DEV_ID);
  wire last_x  = !multi_q && (!is_word || hi_q);
  wire [7:0] tx_src = info_q ? INFO_BYTE : tx_byte;
  wire frame_end = rise_w && (cnt_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ctl_q <= 1'b0;
      sh_q  <= '0;
    end else if (rise_w) begin
      if (cnt_q == 4'd0) begin
        if (bit_w) cnt_q <= 4'd1;
      end else begin
        cnt_q <= (cnt_q == LAST_BIT) ? 4'd0 : cnt_q + 4'd1;
        if (cnt_q == 4'd1) ctl_q <= bit_w;
        if (cnt_q >= D0_BIT && cnt_q <= D7_BIT) sh_q <= {bit_w, sh_q[7:1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_dat_oe  <= 1'b0;
      bus_dat_out <= 1'b0;
      txsh_q      <= '0;
    end else if (fall_w) begin
      if (cnt_q == D0_BIT && ctl_q && sel_q && is_tx) begin
        bus_dat_oe  <= 1'b1;
        bus_dat_out <= tx_src[0];
        txsh_q      <= {1'b0, tx_src[7:1]};
      end else if (bus_dat_oe && cnt_q < LAST_BIT) begin
        bus_dat_out <= txsh_q[0];
        txsh_q      <= {1'b0, txsh_q[7:1]};
      end else begin
        bus_dat_oe  <= 1'b0;
        bus_dat_out <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      st_q       <= W_CTL;
      multi_q    <= 1'b0;
      hi_q       <= 1'b0;
      info_q     <= 1'b0;
      rx_strobe  <= 1'b0;
      rx_byte    <= '0;
      tx_req     <= 1'b0;
      cmd_nibble <= '0;
      cmd_strobe <= 1'b0;
      dev_reset  <= 1'b0;
    end else begin
      rx_strobe  <= 1'b0;
      tx_req     <= 1'b0;
      cmd_strobe <= 1'b0;
      dev_reset  <= 1'b0;
      if (frame_end) begin
        if (!ctl_q) begin
          if (!sh_q[7] && !sh_q[6]) begin
            if (id_zero || id_hit) begin
              dev_reset <= 1'b1;
              sel_q     <= 1'b0;
              st_q      <= W_CTL;
              info_q    <= 1'b0;
            end
          end else if (!sh_q[7]) begin
            sel_q   <= id_hit;
            st_q    <= id_hit ? W_TXB : W_CTL;
            info_q  <= id_hit;
            multi_q <= 1'b0;
            hi_q    <= 1'b0;
          end else if (sel_q) begin
            cmd_nibble <= sh_q[3:0];
            cmd_strobe <= 1'b1;
            multi_q    <= sh_q[4];
            hi_q       <= 1'b0;
            info_q     <= 1'b0;
            tx_req     <= sh_q[6];
            case (sh_q[6:5])
              2'b00:   st_q <= W_RXB;
              2'b01:   st_q <= W_RXW;
              2'b10:   st_q <= W_TXB;
              default: st_q <= W_TXW;
            endcase
          end
        end else if (sel_q && st_q != W_CTL) begin
          if (!is_tx) begin
            rx_strobe <= 1'b1;
            rx_byte   <= sh_q;
          end
          hi_q <= is_word ? ~hi_q : 1'b0;
          if (last_x) begin
            st_q   <= W_CTL;
            info_q <= 1'b0;
          end else if (is_tx) begin
            tx_req <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sbus_slave_chk.sv
module sbus_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_dat_oe,
  input logic       rx_strobe,
  input logic       cmd_strobe,
  input logic       dev_reset,
  input logic       tx_req,
  input logic       sel_q,
  input logic [3:0] cnt_q
);
  assert_quiet_unsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> !bus_dat_oe);
  assert_drive_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_dat_oe) |-> cnt_q == 4'd3);
  assert_drive_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_dat_oe) |-> cnt_q == 4'd11 || cnt_q == 4'd0);
  assert_strobes_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_strobe, cmd_strobe, dev_reset}));
  assert_rx_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> sel_q);
  assert_reset_deselects_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> !sel_q);
  assert_txreq_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> sel_q);
endmodule

bind sbus_slave sbus_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_dat_oe(bus_dat_oe), .rx_strobe(rx_strobe),
  .cmd_strobe(cmd_strobe), .dev_reset(dev_reset), .tx_req(tx_req),
  .sel_q(sel_q), .cnt_q(cnt_q)
);

// File: tb/sbus_slave_tb_top.sv
module sbus_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0;
  logic mdrv = 1'b0, mval = 1'b0;
  logic bus_dat_out, bus_dat_oe, rx_strobe, tx_req, cmd_strobe, dev_reset;
  logic [7:0] rx_byte;
  logic [7:0] tx_byte = 8'h50;
  logic [3:0] cmd_nibble;
  wire line = mdrv ? mval : (bus_dat_oe ? bus_dat_out : 1'b0);

  always #2 clk = ~clk;

  sbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat_in(line),
    .bus_dat_out(bus_dat_out), .bus_dat_oe(bus_dat_oe), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte),
    .cmd_nibble(cmd_nibble), .cmd_strobe(cmd_strobe), .dev_reset(dev_reset)
  );

  int total = 0, fails = 0, rxn = 0, rstn = 0, cmdn = 0, txn = 0, coll = 0;
  logic [7:0] rx_last = 8'h00;

  always @(negedge clk) begin
    if (rx_strobe) begin rxn <= rxn + 1; rx_last <= rx_byte; end
    if (dev_reset) rstn <= rstn + 1;
    if (cmd_strobe) cmdn <= cmdn + 1;
    if (tx_req) begin txn <= txn + 1; tx_byte <= 8'h51 + 8'(txn); end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 control, 1 data write, 2 data read, 3 null
  task automatic frame(input int kind, input logic [7:0] b, output logic [7:0] rd, output logic [11:0] oem);
    rd = '0;
    oem = '0;
    for (int i = 0; i < 12; i++) begin
      mdrv = (kind != 3) && (i < 2 || (kind == 1 && i >= 3 && i <= 10) || (kind == 0 && i >= 3 && i <= 10));
      mval = (kind == 3) ? 1'b0 : (i == 0) ? 1'b1 : (i == 1) ? (kind != 0) :
             (i >= 3 && i <= 10) ? b[i-3] : 1'b0;
      repeat (8) @(negedge clk);
      oem[i] = bus_dat_oe;
      if (mdrv && bus_dat_oe) coll++;
      if (i >= 3 && i <= 10) rd[i-3] = line;
      bus_clk = 1'b1;
      repeat (8) @(negedge clk);
      bus_clk = 1'b0;
    end
    mdrv = 1'b0;
    mval = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  localparam int NV = 34;
  localparam logic [18:0] VEC [NV] = '{
    {2'd1, 8'h11, 1'b0, 8'h00},  // R4 unselected write ignored
    {2'd2, 8'h00, 1'b0, 8'h00},  // R4 unselected read: no drive
    {2'd0, 8'h47, 1'b0, 8'h00},  // R4 select other address
    {2'd2, 8'h00, 1'b0, 8'h00},
    {2'd0, 8'h55, 1'b0, 8'h00},  // R3 select own address
    {2'd2, 8'h00, 1'b1, 8'h3C},  // R3 information byte
    {2'd2, 8'h00, 1'b0, 8'h00},  // R9 back to control only
    {2'd0, 8'h83, 1'b0, 8'h00},  // write single
    {2'd1, 8'hA5, 1'b1, 8'hA5},  // R7
    {2'd1, 8'h5A, 1'b0, 8'h00},  // R9 single done
    {2'd0, 8'h90, 1'b0, 8'h00},  // write repeated
    {2'd1, 8'h01, 1'b1, 8'h01},
    {2'd1, 8'hFE, 1'b1, 8'hFE},
    {2'd0, 8'hC0, 1'b0, 8'h00},  // read single
    {2'd2, 8'h00, 1'b1, 8'h51},  // R8
    {2'd2, 8'h00, 1'b0, 8'h00},
    {2'd0, 8'hD0, 1'b0, 8'h00},  // read repeated
    {2'd2, 8'h00, 1'b1, 8'h52},
    {2'd2, 8'h00, 1'b1, 8'h53},
    {2'd0, 8'hE0, 1'b0, 8'h00},  // R11 control during repeated read; pair read
    {2'd2, 8'h00, 1'b1, 8'h55},  // R10 low byte
    {2'd2, 8'h00, 1'b1, 8'h56},  // R10 high byte
    {2'd2, 8'h00, 1'b0, 8'h00},  // R10 pair done
    {2'd0, 8'hA0, 1'b0, 8'h00},  // pair write single
    {2'd1, 8'h12, 1'b1, 8'h12},
    {2'd1, 8'h34, 1'b1, 8'h34},
    {2'd1, 8'h77, 1'b0, 8'h00},
    {2'd0, 8'hB0, 1'b0, 8'h00},  // pair write repeated
    {2'd1, 8'h21, 1'b1, 8'h21},
    {2'd1, 8'h43, 1'b1, 8'h43},
    {2'd1, 8'h65, 1'b1, 8'h65},
    {2'd0, 8'h40, 1'b0, 8'h00},  // R4 deselect
    {2'd1, 8'h99, 1'b0, 8'h00},
    {2'd2, 8'h00, 1'b0, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [11:0] oem;
    int r0, c0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_dat_oe && !bus_dat_out && !rx_strobe && !tx_req && !cmd_strobe && !dev_reset,
        "R1 reset outputs", {bus_dat_oe, bus_dat_out, rx_strobe, tx_req, cmd_strobe, dev_reset}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] k;
      logic [7:0] din, xv;
      logic xf;
      {k, din, xf, xv} = VEC[v];
      r0 = rxn;
      frame(int'(k), din, rd, oem);
      if (k == 2'd1) begin
        chk(rxn - r0 == int'(xf), $sformatf("R7 step %0d rx count", v), rxn - r0, xf);
        if (xf) chk(rx_last == xv, $sformatf("R7 step %0d rx byte", v), rx_last, xv);
      end else if (k == 2'd2) begin
        chk(oem == (xf ? 12'h7F8 : 12'h000), $sformatf("R8 step %0d drive window", v), oem, xf ? 12'h7F8 : 12'h0);
        chk(rd == xv, $sformatf("R8 step %0d read byte", v), rd, xv);
      end
    end

    // R3 reselect and information byte again
    frame(0, 8'h55, rd, oem);
    frame(2, 8'h00, rd, oem);
    chk(rd == 8'h3C && oem == 12'h7F8, "R3 info byte", rd, 8'h3C);
    // R5 reset aimed at another address has no effect
    r0 = rstn;
    frame(0, 8'h07, rd, oem);
    chk(rstn == r0, "R5 other-address reset", rstn - r0, 0);
    // R6 command nibble
    c0 = cmdn;
    frame(0, 8'h8B, rd, oem);
    chk(cmdn == c0 + 1 && cmd_nibble == 4'hB, "R6 nibble", {cmdn - c0, cmd_nibble}, {32'd1, 4'hB});
    // R2 null frame skipped, following frame still aligned
    frame(3, 8'h00, rd, oem);
    r0 = rxn;
    frame(1, 8'h6C, rd, oem);
    chk(rxn == r0 + 1 && rx_last == 8'h6C, "R2 realign after null frame", rx_last, 8'h6C);
    // R5 reset own address deselects
    r0 = rstn;
    frame(0, 8'h15, rd, oem);
    chk(rstn == r0 + 1, "R5 own-address reset pulse", rstn - r0, 1);
    frame(2, 8'h00, rd, oem);
    chk(oem == 12'h000, "R5 deselected after reset", oem, 0);
    // R5 reset-all after select
    frame(0, 8'h55, rd, oem);
    r0 = rstn;
    frame(0, 8'h00, rd, oem);
    chk(rstn == r0 + 1, "R5 reset-all pulse", rstn - r0, 1);
    // R6 transfer command ignored while unselected
    c0 = cmdn;
    frame(0, 8'h80, rd, oem);
    chk(cmdn == c0, "R6 unselected command ignored", cmdn - c0, 0);
    r0 = rxn;
    frame(1, 8'h33, rd, oem);
    chk(rxn == r0, "R4 unselected write ignored", rxn - r0, 0);
    // R8 no contention on the line at any time
    chk(coll == 0, "R8 line contention", coll, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule